// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the effective address of a memory operand for a 32-bit machine with eight general registers. An operand request names a base register, an index register, a scale code and a displacement of selectable length. The block reads the base and index values through a register-file read port, then adds the base, the index shifted by the scale and the sign-extended displacement in a single step. The sum wraps modulo 2^32, and the result is registered one cycle after the request.

Every term of the sum is optional. A low base-enable input removes the base. The stack-pointer code in the index field removes the index. A zero-length displacement removes the displacement. The same datapath also serves an address-compute mode. In that mode the sum is returned as a data result for a destination register and no memory access is raised. This lets the unit compute expressions of the form x + k*y + c without touching the condition flags.

Top module: `agu_ea_unit`

## Requirements
- R1: One cycle after a cycle with `req_valid` high, `out_valid` is high and `out_addr` equals base term + index term + displacement term, modulo 2^32.
- R2: `scale_code` multiplies the index value: 00 gives x1, 01 gives x2, 10 gives x4 and 11 gives x8.
- R3: `disp_len` selects the displacement. 00 gives zero. 01 sign-extends bits 7:0. 10 sign-extends bits 15:0. 11 uses all 32 bits. Bits above the selected length have no effect.
- R4: With `base_use` low the base term is zero. With `base_use` high the base term is the value of the register named by `base_sel`.
- R5: `index_sel` equal to 4 (the stack-pointer code) means no index, and the index term is zero for every scale code. Any other code selects that register's value.
- R6: Every register code 0 to 7 is accepted as the base, including code 4.
- R7: In address-compute mode (`req_lea` high) the result cycle has `out_wb` high, `out_mem` low and `out_dest` equal to the requested `dest_sel`. In memory mode (`req_lea` low) it has `out_mem` high and `out_wb` low.
- R8: `out_flag_wr` is low in every cycle and in both modes, so condition flags are never written.
- R9: While reset is held, and in the first cycle after it, `out_valid`, `out_mem` and `out_wb` are low and `out_addr` is zero.
- R10: One cycle after a cycle with `req_valid` low, `out_valid`, `out_mem` and `out_wb` are all low.
- R11: Address-compute mode evaluates x + k*y + c exactly, with k in {1,2,4,8}, x taken from the base, y from the index and c from the displacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operand request this cycle |
| req_lea | input | 1 | 1 = address-compute mode, 0 = memory operand |
| base_use | input | 1 | 1 = include the base register |
| base_sel | input | 3 | Base register code |
| index_sel | input | 3 | Index register code; 4 = no index |
| scale_code | input | 2 | Index shift amount (x1, x2, x4, x8) |
| disp_val | input | 32 | Raw displacement |
| disp_len | input | 2 | Displacement length: none, 8, 16 or 32 bits |
| dest_sel | input | 3 | Destination register for address-compute mode |
| rf_base_sel | output | 3 | Register-file read address for the base |
| rf_index_sel | output | 3 | Register-file read address for the index |
| rf_base_data | input | 32 | Base register value (same cycle) |
| rf_index_data | input | 32 | Index register value (same cycle) |
| out_valid | output | 1 | Result valid |
| out_mem | output | 1 | Result is a memory address |
| out_wb | output | 1 | Result is written to `out_dest` |
| out_dest | output | 3 | Destination register of the result |
| out_addr | output | 32 | Effective address or computed value |
| out_flag_wr | output | 1 | Condition-flag write strobe; always low |

## Verification
The bound checker watches the request-to-result pipeline on every cycle. It checks that a result follows each request and that idle cycles follow idle ones, that the memory and write-back strobes are mutually exclusive, that the destination tracks the request, and that the flag strobe stays low. It also checks the sums that can be predicted from ports alone: an all-terms-off request gives zero, a displacement-only request returns the full displacement, and a base-only request returns the base value.

Full address arithmetic needs the bench's scenarios. These cover every scale code, sign extension of 8- and 16-bit displacements with junk in their upper bits, index suppression under a non-unit scale, the stack-pointer register used as a base, modulo-2^32 wrap, and an x + 8y + 4 computation.

// File: rtl/agu_pkg.sv
package agu_pkg;
   typedef enum logic [1:0] {
      DLEN_NONE = 2'b00,
      DLEN_B8   = 2'b01,
      DLEN_B16  = 2'b10,
      DLEN_FULL = 2'b11
   } disp_len_e;

   typedef enum logic {
      MODE_MEM = 1'b0,
      MODE_LEA = 1'b1
   } agu_mode_e;
endpackage

// File: rtl/agu_disp_ext.sv
module agu_disp_ext #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] raw,
   input  logic [1:0]      len,
   output logic [XLEN-1:0] ext
);
   import agu_pkg::*;
   localparam int NARROW_W = 8;
   localparam int HALF_W   = 16;

   generate
      if (XLEN < HALF_W) begin : g_width_bad
         $error("agu_disp_ext: XLEN must be at least 16");
      end
   endgenerate

   logic [XLEN-1:0] ext_b8, ext_b16;
   assign ext_b8  = {{(XLEN-NARROW_W){raw[NARROW_W-1]}}, raw[NARROW_W-1:0]};
   assign ext_b16 = {{(XLEN-HALF_W){raw[HALF_W-1]}}, raw[HALF_W-1:0]};

   always_comb begin
      case (disp_len_e'(len))
         DLEN_NONE: ext = '0;
         DLEN_B8:   ext = ext_b8;
         DLEN_B16:  ext = ext_b16;
         default:   ext = raw;
      endcase
   end
endmodule

// File: rtl/agu_index_path.sv
module agu_index_path #(
   parameter int XLEN       = 32,
   parameter int RSEL_W     = 3,
   parameter int SCALE_W    = 2,
   parameter int NOIDX_CODE = 4,
   parameter bit USE_SHIFT  = 1'b1
) (
   input  logic [RSEL_W-1:0]  sel,
   input  logic [XLEN-1:0]    data,
   input  logic [SCALE_W-1:0] scale,
   output logic [XLEN-1:0]    term
);
   localparam int MAX_SHIFT = (1 << SCALE_W) - 1;

   generate
      if (NOIDX_CODE >= (1 << RSEL_W)) begin : g_code_bad
         $error("agu_index_path: NOIDX_CODE outside register range");
      end
      if (MAX_SHIFT >= XLEN) begin : g_scale_bad
         $error("agu_index_path: scale range exceeds data width");
      end
   endgenerate

   logic            no_index;
   logic [XLEN-1:0] scaled;

   assign no_index = (sel == RSEL_W'(NOIDX_CODE));

   generate
      if (USE_SHIFT) begin : g_shift
         assign scaled = data << scale;
      end else begin : g_mult
         logic [XLEN-1:0] factor;
         assign factor = XLEN'(1) << scale;
         assign scaled = data * factor;
      end
   endgenerate

   assign term = no_index ? '0 : scaled;
endmodule

// File: rtl/agu_sum3.sv
module agu_sum3 #(
   parameter int XLEN    = 32,
   parameter bit USE_CSA = 1'b1
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic [XLEN-1:0] c,
   output logic [XLEN-1:0] sum
);
   generate
      if (USE_CSA) begin : g_csa
         logic [XLEN-1:0] partial, carry;
         assign partial = a ^ b ^ c;
         assign carry   = ((a & b) | (a & c) | (b & c)) << 1;
         assign sum     = partial + carry;
      end else begin : g_ripple
         assign sum = a + b + c;
      end
   endgenerate
endmodule

// File: rtl/agu_ea_unit.sv
module agu_ea_unit #(
   parameter int XLEN       = 32,
   parameter int NREG       = 8,
   parameter int SCALE_W    = 2,
   parameter int NOIDX_CODE = 4,
   parameter bit USE_SHIFT  = 1'b1,
   parameter bit USE_CSA    = 1'b1,
   localparam int RSEL_W    = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_lea,
   input  logic              base_use,
   input  logic [2:0]        base_sel,
   input  logic [2:0]        index_sel,
   input  logic [1:0]        scale_code,
   input  logic [31:0]       disp_val,
   input  logic [1:0]        disp_len,
   input  logic [2:0]        dest_sel,
   output logic [2:0]        rf_base_sel,
   output logic [2:0]        rf_index_sel,
   input  logic [31:0]       rf_base_data,
   input  logic [31:0]       rf_index_data,
   output logic              out_valid,
   output logic              out_mem,
   output logic              out_wb,
   output logic [2:0]        out_dest,
   output logic [31:0]       out_addr,
   output logic              out_flag_wr
);
   import agu_pkg::*;

   generate
      if (XLEN != 32) begin : g_xlen_bad
         $error("agu_ea_unit: port widths are fixed at 32 bits");
      end
      if (RSEL_W != 3) begin : g_nreg_bad
         $error("agu_ea_unit: port widths assume eight registers");
      end
      if (SCALE_W != 2) begin : g_scale_bad
         $error("agu_ea_unit: scale code port is two bits");
      end
   endgenerate

   logic [XLEN-1:0] base_term, index_term, disp_term, ea_sum;

   assign rf_base_sel  = base_sel;
   assign rf_index_sel = index_sel;
   assign base_term    = base_use ? rf_base_data : '0;

   agu_index_path #(
      .XLEN(XLEN), .RSEL_W(RSEL_W), .SCALE_W(SCALE_W),
      .NOIDX_CODE(NOIDX_CODE), .USE_SHIFT(USE_SHIFT)
   ) u_index (
      .sel(index_sel), .data(rf_index_data), .scale(scale_code), .term(index_term)
   );

   agu_disp_ext #(.XLEN(XLEN)) u_disp (
      .raw(disp_val), .len(disp_len), .ext(disp_term)
   );

   agu_sum3 #(.XLEN(XLEN), .USE_CSA(USE_CSA)) u_sum (
      .a(base_term), .b(index_term), .c(disp_term), .sum(ea_sum)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_mem   <= 1'b0;
         out_wb    <= 1'b0;
         out_dest  <= '0;
         out_addr  <= '0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            out_addr <= ea_sum;
            out_dest <= dest_sel;
            out_wb   <= (agu_mode_e'(req_lea) == MODE_LEA);
            out_mem  <= (agu_mode_e'(req_lea) == MODE_MEM);
         end else begin
            out_wb   <= 1'b0;
            out_mem  <= 1'b0;
         end
      end
   end

   // Neither mode alters condition flags.
   assign out_flag_wr = 1'b0;
endmodule

// File: rtl/agu_ea_unit_chk.sv
module agu_ea_unit_chk #(
   parameter int NOIDX_CODE = 4
) (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_lea,
   input logic        base_use,
   input logic [2:0]  index_sel,
   input logic [31:0] disp_val,
   input logic [1:0]  disp_len,
   input logic [2:0]  dest_sel,
   input logic [31:0] rf_base_data,
   input logic        out_valid,
   input logic        out_mem,
   input logic        out_wb,
   input logic [2:0]  out_dest,
   input logic [31:0] out_addr,
   input logic        out_flag_wr
);
   logic idx_off;
   assign idx_off = (index_sel == 3'(NOIDX_CODE));

   p_result_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);

   p_idle_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!out_valid && !out_mem && !out_wb));

   p_mode_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_mem ^ out_wb));

   p_lea_dest_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_lea) |=> (out_wb && out_dest == $past(dest_sel)));

   p_no_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_wb || out_mem || !out_valid) |-> !out_flag_wr);

   p_all_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !base_use && idx_off && disp_len == 2'b00) |=> (out_addr == 32'd0));

   p_disp_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !base_use && idx_off && disp_len == 2'b11) |=> (out_addr == $past(disp_val)));

   p_base_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && base_use && idx_off && disp_len == 2'b00) |=> (out_addr == $past(rf_base_data)));
endmodule

bind agu_ea_unit agu_ea_unit_chk #(.NOIDX_CODE(NOIDX_CODE)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lea(req_lea),
   .base_use(base_use), .index_sel(index_sel), .disp_val(disp_val),
   .disp_len(disp_len), .dest_sel(dest_sel), .rf_base_data(rf_base_data),
   .out_valid(out_valid), .out_mem(out_mem), .out_wb(out_wb),
   .out_dest(out_dest), .out_addr(out_addr), .out_flag_wr(out_flag_wr)
);

// File: tb/tb_agu_ea_unit.sv
module tb_agu_ea_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_lea = 1'b0, base_use = 1'b0;
   logic [2:0] base_sel = '0, index_sel = '0, dest_sel = '0;
   logic [1:0] scale_code = '0, disp_len = '0;
   logic [31:0] disp_val = '0;
   logic [2:0] rf_base_sel, rf_index_sel;
   logic [31:0] rf_base_data, rf_index_data;
   logic out_valid, out_mem, out_wb, out_flag_wr;
   logic [2:0] out_dest;
   logic [31:0] out_addr;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   // Register-file read port model
   logic [31:0] regs [0:7];
   initial begin
      regs[0] = 32'h0000_1000; regs[1] = 32'h0000_0010;
      regs[2] = 32'hFFFF_FFF0; regs[3] = 32'h8000_0000;
      regs[4] = 32'h0000_F000; regs[5] = 32'h1234_5678;
      regs[6] = 32'h0000_0003; regs[7] = 32'h7FFF_FFFF;
   end
   assign rf_base_data  = regs[rf_base_sel];
   assign rf_index_data = regs[rf_index_sel];

   agu_ea_unit dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lea(req_lea),
      .base_use(base_use), .base_sel(base_sel), .index_sel(index_sel),
      .scale_code(scale_code), .disp_val(disp_val), .disp_len(disp_len),
      .dest_sel(dest_sel), .rf_base_sel(rf_base_sel), .rf_index_sel(rf_index_sel),
      .rf_base_data(rf_base_data), .rf_index_data(rf_index_data),
      .out_valid(out_valid), .out_mem(out_mem), .out_wb(out_wb),
      .out_dest(out_dest), .out_addr(out_addr), .out_flag_wr(out_flag_wr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] sext(input logic [31:0] d, input logic [1:0] ln);
      case (ln)
         2'b00:   return 32'd0;
         2'b01:   return {{24{d[7]}}, d[7:0]};
         2'b10:   return {{16{d[15]}}, d[15:0]};
         default: return d;
      endcase
   endfunction

   function automatic logic [31:0] model(input logic bu, input logic [2:0] b,
         input logic [2:0] i, input logic [1:0] sc, input logic [31:0] d, input logic [1:0] ln);
      logic [31:0] bt, it;
      bt = bu ? regs[b] : 32'd0;
      it = (i == 3'd4) ? 32'd0 : (regs[i] << sc);
      return bt + it + sext(d, ln);
   endfunction

   // {lea, base_use, base, index, scale, len, disp, dest}
   localparam int NV = 12;
   localparam logic [46:0] VEC [0:NV-1] = '{
      {1'b0, 1'b1, 3'd5, 3'd4, 2'd0, 2'd0, 32'h0000_0000, 3'd0},  // base alone
      {1'b0, 1'b1, 3'd0, 3'd1, 2'd0, 2'd0, 32'h0000_0000, 3'd0},  // base + index
      {1'b0, 1'b1, 3'd0, 3'd1, 2'd1, 2'd1, 32'h0000_0008, 3'd0},  // x2, byte disp
      {1'b0, 1'b1, 3'd0, 3'd1, 2'd2, 2'd2, 32'h0000_FFF0, 3'd0},  // x4, -16
      {1'b0, 1'b1, 3'd0, 3'd1, 2'd3, 2'd3, 32'h0000_0100, 3'd0},  // x8, word
      {1'b0, 1'b0, 3'd7, 3'd6, 2'd3, 2'd1, 32'h0000_0080, 3'd0},  // no base, -128
      {1'b0, 1'b1, 3'd4, 3'd0, 2'd0, 2'd0, 32'h0000_0000, 3'd0},  // SP as base
      {1'b0, 1'b1, 3'd2, 3'd4, 2'd3, 2'd1, 32'h0000_0020, 3'd0},  // no index, x8
      {1'b1, 1'b1, 3'd0, 3'd6, 2'd3, 2'd1, 32'h0000_0004, 3'd3},  // x + 8y + 4
      {1'b1, 1'b1, 3'd3, 3'd3, 2'd0, 2'd0, 32'h0000_0000, 3'd7},  // wrap to 0
      {1'b0, 1'b1, 3'd7, 3'd7, 2'd1, 2'd3, 32'hFFFF_FFFF, 3'd0},  // wrap, -1
      {1'b1, 1'b0, 3'd0, 3'd4, 2'd0, 2'd2, 32'hABCD_8000, 3'd5}   // junk upper bits
   };

   task automatic issue(input logic [46:0] v);
      @(negedge clk);
      {req_lea, base_use, base_sel, index_sel, scale_code, disp_len, disp_val, dest_sel} = v;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic check_result(input logic [46:0] v, input string tag);
      logic lea;
      lea = v[46];
      chk({tag, " R1 valid"}, {31'd0, out_valid}, 32'd1);
      chk({tag, " R1 addr"}, out_addr,
          model(v[45], v[44:42], v[41:39], v[38:37], v[34:3], v[36:35]));
      chk({tag, " R7 wb"}, {31'd0, out_wb}, {31'd0, lea});
      chk({tag, " R7 mem"}, {31'd0, out_mem}, {31'd0, ~lea});
      if (lea) chk({tag, " R7 dest"}, {29'd0, out_dest}, {29'd0, v[2:0]});
      chk({tag, " R8 flags"}, {31'd0, out_flag_wr}, 32'd0);
   endtask

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      chk("R9 valid in reset", {31'd0, out_valid}, 32'd0);
      chk("R9 addr in reset", out_addr, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 mem after reset", {31'd0, out_mem}, 32'd0);
      chk("R9 wb after reset", {31'd0, out_wb}, 32'd0);

      // Vector table: R1 R2 R3 R4 R5 R6 R7 R8 R11
      for (int k = 0; k < NV; k++) begin
         issue(VEC[k]);
         check_result(VEC[k], $sformatf("vec%0d", k));
      end

      // Directed: R11 x + 8*y + 4 = 0x1000 + 24 + 4
      issue(VEC[8]);
      chk("R11 lea arithmetic", out_addr, 32'h0000_101C);
      // R2 scale codes one by one on fixed index r1 = 0x10
      for (int s = 0; s < 4; s++) begin
         issue({1'b0, 1'b0, 3'd0, 3'd1, 2'(s), 2'd0, 32'd0, 3'd0});
         chk($sformatf("R2 scale code %0d", s), out_addr, 32'h10 << s);
      end
      // R5: index code 4 ignored under every scale
      issue({1'b0, 1'b0, 3'd0, 3'd4, 2'd3, 2'd0, 32'd0, 3'd0});
      chk("R5 no index", out_addr, 32'd0);
      // R3: junk above byte ignored, 0x..7F positive
      issue({1'b0, 1'b0, 3'd0, 3'd4, 2'd0, 2'd1, 32'hFFFF_FF7F, 3'd0});
      chk("R3 byte upper ignored", out_addr, 32'h0000_007F);
      issue({1'b0, 1'b0, 3'd0, 3'd4, 2'd0, 2'd0, 32'hDEAD_BEEF, 3'd0});
      chk("R3 no disp", out_addr, 32'd0);
      // R4: base_use low removes base of r5
      issue({1'b0, 1'b0, 3'd5, 3'd4, 2'd0, 2'd3, 32'h0000_0040, 3'd0});
      chk("R4 base off", out_addr, 32'h0000_0040);
      // R6: SP code as base
      issue({1'b0, 1'b1, 3'd4, 3'd4, 2'd0, 2'd0, 32'd0, 3'd0});
      chk("R6 base code 4", out_addr, 32'h0000_F000);
      // R10: idle cycle after the last result
      @(negedge clk);
      chk("R10 idle valid", {31'd0, out_valid}, 32'd0);
      chk("R10 idle mem", {31'd0, out_mem}, 32'd0);
      chk("R10 idle wb", {31'd0, out_wb}, 32'd0);
      chk("R8 idle flags", {31'd0, out_flag_wr}, 32'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule